// File: doc/BRIEF.md
# Clock Alarm Edge Interrupt Capture

This block sits beside a redundant telecom clock PLL. It watches four level alarms: primary reference lost, secondary reference lost, holdover active and loop unlocked. Every transition of each alarm, in either direction, is recorded in a sticky bit of an 8-bit cause register. A level interrupt goes to the host while any recorded cause is also enabled in a mask register. The host also reads the live alarm levels and which redundant reference is in use, through a byte-wide port with a 3-bit offset and read and write strobes.

Reading the cause register returns every event collected since the previous read and empties it in the same cycle. The host therefore takes losses and recoveries together with one access. A read made before the interrupt is enabled throws away stale events. Alarm inputs and the reference indication are asynchronous; each passes through a synchronizer chain before it is used.

Top module: `clk_alarm_irq_cap`

## Requirements
- R1: Cause bit 2k records a 0-to-1 change and bit 2k+1 records a 1-to-0 change of alarm k, where k=0 is primary lost (`los_pri_i`), k=1 is secondary lost (`los_sec_i`), k=2 is holdover (`holdover_i`) and k=3 is unlock (`unlock_i`). A change reaches the cause register SYNC_STAGES+1 clock edges after the input moves.
- R2: Cause bits are sticky. A pulse that rises and falls between two reads leaves both its rise and its fall bit set.
- R3: A read at offset 6 returns the cause register and clears it. A write to offset 6 has no effect on the register.
- R4: An edge that is captured on the same clock edge as a clearing read is not returned by that read. It stays set and is returned by the next read.
- R5: `irq_o` is high exactly while some cause bit and the same bit of the enable mask are both 1. The mask is read and written at offset 4 and resets to 0x00.
- R6: A read at offset 2 returns the synchronized live alarms as follows: bit 7 is primary lost, bit 6 is secondary lost, bit 5 is holdover and bit 4 is unlock. Bits 3..0 read 0.
- R7: A read at offset 1 returns the synchronized `ref_sel_i` in bit 3, with all other bits 0. Offsets 0 and 3 read 0x00.
- R8: A read at offset 5 returns VERSION and a read at offset 7 returns {4'h0, IRQ_LINE}. Writes to these offsets are ignored.
- R9: During and after reset, `rdata_o`, `irq_o`, the cause register and the mask are all 0. With the alarms low, no event is recorded after reset. `rdata_o` is registered: it takes the addressed value on the clock edge that samples `rd_i` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| los_pri_i | input | 1 | Primary reference lost (async level) |
| los_sec_i | input | 1 | Secondary reference lost (async level) |
| holdover_i | input | 1 | PLL in holdover (async level) |
| unlock_i | input | 1 | PLL unlocked (async level) |
| ref_sel_i | input | 1 | Redundant reference in use, 1 = secondary (async level) |
| addr_i | input | 3 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case is an edge that lands on the same clock edge as a clearing read. A design that clears after setting would lose that event for good, and a design that returns the new bit early would report it twice. The bench also sends a short pulse on one alarm between reads, which catches a design that keeps only the latest direction of change. It enables the mask for one bit only while a different bit is set, which catches an interrupt that ignores the mask. Finally it writes to the read-only and read-clear offsets, which catches decode that clobbers state.

// File: rtl/clk_alarm_pkg.sv
package clk_alarm_pkg;
   localparam int NUM_ALARMS = 4;
   localparam int DATA_W     = 8;
   localparam int ADDR_W     = 3;

   // alarm index inside the status vector
   localparam int AL_PRI  = 0;
   localparam int AL_SEC  = 1;
   localparam int AL_HOLD = 2;
   localparam int AL_UNLK = 3;

   typedef enum logic [ADDR_W-1:0] {
      OFS_NONE0 = 3'd0,
      OFS_REF   = 3'd1,
      OFS_LIVE  = 3'd2,
      OFS_NONE3 = 3'd3,
      OFS_MASK  = 3'd4,
      OFS_VER   = 3'd5,
      OFS_CAUSE = 3'd6,
      OFS_LINE  = 3'd7
   } reg_ofs_e;

   localparam int REF_BIT = 3;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("alarm_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("alarm_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/alarm_edge_cap.sv
module alarm_edge_cap #(
   parameter int N = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   lvl_i,
   input  logic           clr_i,
   output logic [2*N-1:0] cause_o
);
   localparam int CW = 2 * N;

   if (N < 1) begin : g_bad_n
      $error("alarm_edge_cap: N must be positive");
   end

   logic [N-1:0]  prev_q;
   logic [CW-1:0] set_vec;
   logic [CW-1:0] cause_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   for (genvar k = 0; k < N; k++) begin : g_edge
      assign set_vec[2*k]   =  lvl_i[k] & ~prev_q[k];
      assign set_vec[2*k+1] = ~lvl_i[k] &  prev_q[k];
   end

   // clear first, then merge new events so none are lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cause_q <= '0;
      else if (clr_i) cause_q <= set_vec;
      else            cause_q <= cause_q | set_vec;
   end

   assign cause_o = cause_q;

   // R4
   clear_no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && (set_vec != '0)) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));
   // R2
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
   // R3
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && (set_vec == '0)) |=> (cause_q == '0));
endmodule

// File: rtl/alarm_regport.sv
module alarm_regport
   import clk_alarm_pkg::*;
#(
   parameter logic [DATA_W-1:0] VERSION  = 8'h21,
   parameter logic [3:0]        IRQ_LINE = 4'h5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic                  wr_i,
   input  logic                  rd_i,
   input  logic [DATA_W-1:0]     wdata_i,
   input  logic [DATA_W-1:0]     cause_i,
   input  logic [NUM_ALARMS-1:0] live_i,
   input  logic                  ref_i,
   output logic                  clr_o,
   output logic [DATA_W-1:0]     rdata_o,
   output logic                  irq_o
);
   if (IRQ_LINE == 4'hF) begin : g_bad_line
      $error("alarm_regport: IRQ_LINE 0xF is reserved for absent hardware");
   end

   reg_ofs_e          ofs;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] live_byte;
   logic [DATA_W-1:0] rdata_q;

   assign ofs = reg_ofs_e'(addr_i);

   // live alarms in the upper nibble, primary at the top
   always_comb begin
      live_byte = '0;
      for (int k = 0; k < NUM_ALARMS; k++)
         live_byte[DATA_W-1-k] = live_i[k];
   end

   always_comb begin
      rd_mux = '0;
      unique case (ofs)
         OFS_REF:   rd_mux[REF_BIT] = ref_i;
         OFS_LIVE:  rd_mux = live_byte;
         OFS_MASK:  rd_mux = mask_q;
         OFS_VER:   rd_mux = VERSION;
         OFS_CAUSE: rd_mux = cause_i;
         OFS_LINE:  rd_mux = {4'h0, IRQ_LINE};
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      mask_q <= '0;
      else if (wr_i && ofs == OFS_MASK) mask_q <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_q <= '0;
      else if (rd_i) rdata_q <= rd_mux;
   end

   assign clr_o   = rd_i && (ofs == OFS_CAUSE);
   assign rdata_o = rdata_q;
   assign irq_o   = |(cause_i & mask_q);

   // R5
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_o);
   // R8
   version_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && ofs == OFS_VER) |=> (rdata_o == VERSION));
   // R8
   line_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && ofs == OFS_LINE) |=> (rdata_o[7:4] == 4'h0));
endmodule

// File: rtl/clk_alarm_irq_cap.sv
module clk_alarm_irq_cap
   import clk_alarm_pkg::*;
#(
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  VERSION     = 8'h21,
   parameter logic [3:0]  IRQ_LINE    = 4'h5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       los_pri_i,
   input  logic       los_sec_i,
   input  logic       holdover_i,
   input  logic       unlock_i,
   input  logic       ref_sel_i,
   input  logic [2:0] addr_i,
   input  logic       wr_i,
   input  logic       rd_i,
   input  logic [7:0] wdata_i,
   output logic [7:0] rdata_o,
   output logic       irq_o
);
   localparam int SYNC_W = NUM_ALARMS + 1;

   if (2 * NUM_ALARMS != DATA_W) begin : g_bad_width
      $error("clk_alarm_irq_cap: cause register must hold two bits per alarm");
   end

   logic [SYNC_W-1:0]     raw_in;
   logic [SYNC_W-1:0]     sync_q;
   logic [NUM_ALARMS-1:0] live;
   logic [DATA_W-1:0]     cause;
   logic                  clr;

   always_comb begin
      raw_in          = '0;
      raw_in[AL_PRI]  = los_pri_i;
      raw_in[AL_SEC]  = los_sec_i;
      raw_in[AL_HOLD] = holdover_i;
      raw_in[AL_UNLK] = unlock_i;
      raw_in[NUM_ALARMS] = ref_sel_i;
   end

   alarm_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (sync_q)
   );

   assign live = sync_q[NUM_ALARMS-1:0];

   alarm_edge_cap #(.N(NUM_ALARMS)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (live),
      .clr_i   (clr),
      .cause_o (cause)
   );

   alarm_regport #(.VERSION(VERSION), .IRQ_LINE(IRQ_LINE)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (addr_i),
      .wr_i    (wr_i),
      .rd_i    (rd_i),
      .wdata_i (wdata_i),
      .cause_i (cause),
      .live_i  (live),
      .ref_i   (sync_q[NUM_ALARMS]),
      .clr_o   (clr),
      .rdata_o (rdata_o),
      .irq_o   (irq_o)
   );

   // R9
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (cause != '0));
endmodule

// File: tb/clk_alarm_irq_cap_tb.sv
module clk_alarm_irq_cap_tb;
   localparam logic [7:0] VER  = 8'h21;
   localparam logic [3:0] LINE = 4'h5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       los_pri = 0, los_sec = 0, hold = 0, unlk = 0, ref_sel = 0;
   logic [2:0] addr = '0;
   logic       wr = 0, rd = 0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata_o;
   logic       irq_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   clk_alarm_irq_cap #(.SYNC_STAGES(2), .VERSION(VER), .IRQ_LINE(LINE)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .los_pri_i(los_pri), .los_sec_i(los_sec), .holdover_i(hold),
      .unlock_i(unlk), .ref_sel_i(ref_sel),
      .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
      .rdata_o(rdata_o), .irq_o(irq_o)
   );

   // {alarm levels [3]=unlock [2]=holdover [1]=sec [0]=pri, expected cause}
   localparam logic [11:0] VEC [7] = '{
      {4'b0001, 8'h01},
      {4'b0011, 8'h04},
      {4'b0010, 8'h02},
      {4'b1100, 8'h58},
      {4'b0000, 8'hA0},
      {4'b1111, 8'h55},
      {4'b0000, 8'hAA}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1;
      @(negedge clk); rd = 1'b0; d = rdata_o;
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic set_lv(input logic [3:0] s);
      @(negedge clk);
      los_pri = s[0]; los_sec = s[1]; hold = s[2]; unlk = s[3];
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 rdata in reset", rdata_o, 8'h00);
      chk("R9 irq in reset", {7'b0, irq_o}, 8'h00);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      reg_rd(3'd6, d); chk("R9 cause after reset", d, 8'h00);
      reg_rd(3'd4, d); chk("R9 mask after reset", d, 8'h00);
      chk("R9 irq after reset", {7'b0, irq_o}, 8'h00);

      // R1 R3 R6 table walk
      foreach (VEC[i]) begin
         logic [3:0] s;
         s = VEC[i][11:8];
         set_lv(s);
         reg_rd(3'd2, d);
         chk("R6 live alarms", d, {s[0], s[1], s[2], s[3], 4'h0});
         reg_rd(3'd6, d); chk("R1 cause edges", d, VEC[i][7:0]);
         reg_rd(3'd6, d); chk("R3 cleared by read", d, 8'h00);
      end

      // R2 short pulse on holdover keeps both directions
      @(negedge clk); hold = 1'b1;
      repeat (3) @(negedge clk); hold = 1'b0;
      repeat (5) @(negedge clk);
      reg_rd(3'd6, d); chk("R2 pulse both edges", d, 8'h30);

      // R5 mask gating
      reg_wr(3'd4, 8'h01);
      reg_rd(3'd4, d); chk("R5 mask readback", d, 8'h01);
      set_lv(4'b0010);
      chk("R5 irq masked", {7'b0, irq_o}, 8'h00);
      set_lv(4'b0011);
      chk("R5 irq enabled bit", {7'b0, irq_o}, 8'h01);
      reg_rd(3'd6, d); chk("R5 cause value", d, 8'h05);
      chk("R5 irq drops after clear", {7'b0, irq_o}, 8'h00);
      reg_wr(3'd4, 8'h00);
      set_lv(4'b0000);
      reg_rd(3'd6, d);

      // R4 edge coincident with clearing read
      set_lv(4'b0010);                     // cause = 0x04
      @(negedge clk); los_pri = 1'b1;      // captured 3 edges later
      @(negedge clk);
      @(negedge clk); addr = 3'd6; rd = 1'b1;
      @(negedge clk); rd = 1'b0; d = rdata_o;
      chk("R4 read returns older cause", d, 8'h04);
      reg_rd(3'd6, d); chk("R4 coincident edge kept", d, 8'h01);

      // R3 write to cause offset ignored
      set_lv(4'b0000);                     // cause = 0x0A
      reg_wr(3'd6, 8'h00);
      reg_rd(3'd6, d); chk("R3 write does not clear", d, 8'h0A);

      // R8 id registers, writes ignored
      reg_wr(3'd5, 8'h00);
      reg_wr(3'd7, 8'hFF);
      reg_rd(3'd5, d); chk("R8 version", d, VER);
      reg_rd(3'd7, d); chk("R8 line number", d, {4'h0, LINE});

      // R7 reference indication and unmapped offsets
      @(negedge clk); ref_sel = 1'b1;
      repeat (4) @(negedge clk);
      reg_rd(3'd1, d); chk("R7 ref secondary", d, 8'h08);
      reg_rd(3'd0, d); chk("R7 offset 0 zero", d, 8'h00);
      reg_rd(3'd3, d); chk("R7 offset 3 zero", d, 8'h00);
      @(negedge clk); ref_sel = 1'b0;
      repeat (4) @(negedge clk);
      reg_rd(3'd1, d); chk("R7 ref primary", d, 8'h00);

      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule